// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Servo Compare Mode

This block is the synchronous sequencer for an 8-bit charge-redistribution successive-approximation converter. A one-cycle start request begins a conversion. The block then drives the input-sampling switch, the mid-rail hold switch, a reference-enable line and the eight capacitor-array bit switches. On every clock it reads the comparator. When the conversion is finished it raises a one-cycle done strobe.

In normal mode, the input is sampled for a fixed number of clocks. The binary search then settles one bit per clock, starting at the most significant bit, and the resulting code is held on the result port.

Servo mode is meant for fast edge-by-edge linearity testing. It samples an external servo input for one clock. It then applies a target code, taken from a parallel bus when the request starts, to the array for one compare clock. The comparator decision on that clock is returned as a single pass bit.

Between conversions every switch control rests low, so the analog section draws no static current.

Top module: `sar_servo_ctrl`

## Requirements
- R1: After reset, and on every cycle where no conversion is in progress (including the done cycle), `sample_o`, `midhold_o`, `ref_en_o` and all bits of `sw_o` are 0. After reset, `result_o`, `servo_pass_o` and `done_o` are 0.
- R2: In normal mode, `sample_o` and `midhold_o` are both 1 for exactly SAMPLE_CYC (default 8) cycles. These cycles begin in the cycle after the clock edge at which the start request is seen. Throughout them `ref_en_o` is 0 and `sw_o` is 0.
- R3: After sampling, the release happens in three one-cycle steps, in this order. First, a cycle with every control at 0 (hold released, comparator decoupled from mid-rail). Next, a cycle where only the MSB switch `sw_o[7]` may be 1 and `ref_en_o` is 0. Then the cycles with `ref_en_o` = 1, in which the lower switches are driven from the reference.
- R4: In normal mode, each reference-enabled cycle tests one bit, from bit 7 down to bit 0. During the cycle for bit i, `sw_o` holds the bits already decided above i, a 1 at bit i, and 0 below i. `cmp_i` = 1 means the input is at or above the trial level; this value is kept as bit i at the clock edge that ends the cycle. The final code equals floor(input / LSB).
- R5: `done_o` is 1 for exactly one cycle. In normal mode this is the cycle after the edge that decides bit 0, which is SAMPLE_CYC+11 cycles after the start edge (cycle 19 by default). The new result is valid in that cycle. `result_o` and `servo_pass_o` change only in a done cycle.
- R6: In servo mode, `sample_o` and `midhold_o` are 1 for exactly one cycle. The R3 step sequence follows, in which the MSB step shows the target's bit 7. There is then exactly one compare cycle with `sw_o` equal to the target and `ref_en_o` = 1. In the next cycle `done_o` is 1 and `servo_pass_o` holds the value of `cmp_i` from the compare cycle.
- R7: The target code is captured from `target_i` when the start request is accepted. Changes to `target_i` later in the conversion have no effect.
- R8: A start request in the done cycle is accepted, so conversions can run back to back with no idle cycle in between.
- R9: A start request during a conversion is ignored. The ongoing conversion's outputs and timing are unchanged.
- R10: The mode is captured from `servo_mode_i` at start. Changing it mid-conversion has no effect.
- R11: A normal conversion leaves `servo_pass_o` unchanged, and a servo conversion leaves `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| servo_mode_i | input | 1 | 1 selects servo compare mode, captured at start |
| target_i | input | 8 | Target code for servo mode, captured at start |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial level |
| sample_o | output | 1 | Input sampling switch closed |
| midhold_o | output | 1 | Comparator node held at mid-rail |
| ref_en_o | output | 1 | Lower array switches driven from the reference |
| sw_o | output | 8 | Array bit switches, 1 selects the positive reference |
| done_o | output | 1 | One-cycle conversion-complete strobe |
| result_o | output | 8 | Last normal-mode code |
| servo_pass_o | output | 1 | Last servo compare decision |

## Verification
An ideal comparator in the bench works on an input held at quarter-LSB resolution.

Inputs are chosen at both rails, at the half-scale boundary (511 against 512 quarter-LSBs) and at exact code edges. These cases show whether the trial bits are set and cleared in the right order, and whether the decision at the edge goes the right way.

Servo targets are placed one quarter-LSB above, exactly at, and below the input, which tests the direction of the single compare.

Random conversions mix the two modes, idle gaps of zero to two cycles, and mid-conversion changes to start, mode and target. These runs tell apart correct capture at start from late sampling, and back-to-back acceptance from a lost request.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_SAMPLE   = 3'd1,
        PH_DECOUPLE = 3'd2,
        PH_MSB      = 3'd3,
        PH_TRIAL    = 3'd4
    } phase_e;

    typedef struct packed {
        logic sample;
        logic midhold;
        logic ref_en;
    } ana_ctl_t;

    localparam int SERVO_SAMPLE_CYC = 1;

    function automatic int cnt_width(input int samp_cyc, input int nbits);
        int m;
        m = (samp_cyc > nbits) ? samp_cyc : nbits;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int SAMPLE_CYC = 8,
    parameter int CW         = cnt_width(SAMPLE_CYC, NBITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          servo_mode_i,
    output phase_e        phase_o,
    output logic          servo_q_o,
    output logic [CW-1:0] idx_o,
    output logic          start_acc_o,
    output logic          trial_last_o
);

    phase_e        phase_q;
    logic          servo_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] samp_last;

    assign samp_last    = servo_q ? CW'(SERVO_SAMPLE_CYC - 1) : CW'(SAMPLE_CYC - 1);
    assign start_acc_o  = (phase_q == PH_IDLE) && start_i;
    assign trial_last_o = (phase_q == PH_TRIAL) && (cnt_q == '0);
    assign phase_o      = phase_q;
    assign servo_q_o    = servo_q;
    assign idx_o        = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            servo_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SAMPLE;
                        servo_q <= servo_mode_i;
                        cnt_q   <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (cnt_q == samp_last) begin
                        phase_q <= PH_DECOUPLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DECOUPLE: phase_q <= PH_MSB;
                PH_MSB: begin
                    phase_q <= PH_TRIAL;
                    cnt_q   <= servo_q ? '0 : CW'(NBITS - 1);
                end
                PH_TRIAL: begin
                    if (cnt_q == '0) phase_q <= PH_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase_i,
    input  logic             servo_q_i,
    input  logic [CW-1:0]    idx_i,
    input  logic             start_acc_i,
    input  logic             trial_last_i,
    input  logic [NBITS-1:0] target_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] code_o,
    output logic [NBITS-1:0] result_o,
    output logic             servo_pass_o,
    output logic             done_o
);

    logic [NBITS-1:0] code_q;
    logic [NBITS-1:0] code_nx;

    // Resolve the bit under test and arm the one below it.
    always_comb begin
        code_nx = code_q;
        for (int k = 0; k < NBITS; k++) begin
            if (k == int'(idx_i))           code_nx[k] = cmp_i;
            else if (k + 1 == int'(idx_i))  code_nx[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q       <= '0;
            result_o     <= '0;
            servo_pass_o <= 1'b0;
            done_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_acc_i) begin
                code_q <= target_i;
            end else if (phase_i == PH_DECOUPLE && !servo_q_i) begin
                code_q <= {1'b1, {(NBITS-1){1'b0}}};
            end else if (phase_i == PH_TRIAL && !servo_q_i) begin
                code_q <= code_nx;
            end
            if (trial_last_i) begin
                done_o <= 1'b1;
                if (servo_q_i) servo_pass_o <= cmp_i;
                else           result_o     <= code_nx;
            end
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/sar_switch_drv.sv
module sar_switch_drv
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  phase_e           phase_i,
    input  logic [NBITS-1:0] code_i,
    output ana_ctl_t         ctl_o,
    output logic [NBITS-1:0] sw_o
);

    always_comb begin
        ctl_o = '0;
        sw_o  = '0;
        unique case (phase_i)
            PH_SAMPLE: begin
                ctl_o.sample  = 1'b1;
                ctl_o.midhold = 1'b1;
            end
            PH_MSB: sw_o[NBITS-1] = code_i[NBITS-1];
            PH_TRIAL: begin
                ctl_o.ref_en = 1'b1;
                sw_o         = code_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sar_servo_ctrl.sv
module sar_servo_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int SAMPLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             servo_mode_i,
    input  logic [NBITS-1:0] target_i,
    input  logic             cmp_i,
    output logic             sample_o,
    output logic             midhold_o,
    output logic             ref_en_o,
    output logic [NBITS-1:0] sw_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o,
    output logic             servo_pass_o
);

    localparam int CW = cnt_width(SAMPLE_CYC, NBITS);

    phase_e           phase;
    logic             servo_q;
    logic [CW-1:0]    idx;
    logic             start_acc;
    logic             trial_last;
    logic [NBITS-1:0] code;
    ana_ctl_t         ctl;

    sar_phase_seq #(.NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC), .CW(CW)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .servo_mode_i (servo_mode_i),
        .phase_o      (phase),
        .servo_q_o    (servo_q),
        .idx_o        (idx),
        .start_acc_o  (start_acc),
        .trial_last_o (trial_last)
    );

    sar_code_reg #(.NBITS(NBITS), .CW(CW)) code_i (
        .clk          (clk),
        .rst          (rst),
        .phase_i      (phase),
        .servo_q_i    (servo_q),
        .idx_i        (idx),
        .start_acc_i  (start_acc),
        .trial_last_i (trial_last),
        .target_i     (target_i),
        .cmp_i        (cmp_i),
        .code_o       (code),
        .result_o     (result_o),
        .servo_pass_o (servo_pass_o),
        .done_o       (done_o)
    );

    sar_switch_drv #(.NBITS(NBITS)) drv_i (
        .phase_i (phase),
        .code_i  (code),
        .ctl_o   (ctl),
        .sw_o    (sw_o)
    );

    assign sample_o  = ctl.sample;
    assign midhold_o = ctl.midhold;
    assign ref_en_o  = ctl.ref_en;

endmodule

// File: rtl/sar_servo_ctrl_chk.sv
module sar_servo_ctrl_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_o,
    input logic             midhold_o,
    input logic             ref_en_o,
    input logic [NBITS-1:0] sw_o,
    input logic             done_o,
    input logic [NBITS-1:0] result_o,
    input logic             servo_pass_o
);

    // R1
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!sample_o && !midhold_o && !ref_en_o && sw_o == '0));

    // R2
    sample_excl_chk: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> (midhold_o && !ref_en_o && sw_o == '0));

    // R3
    decouple_step_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_o) |-> (!midhold_o && !ref_en_o && sw_o == '0));

    // R3
    ref_after_msb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_en_o) |-> $past(!ref_en_o && !sample_o && !midhold_o));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(servo_pass_o)));

endmodule

bind sar_servo_ctrl sar_servo_ctrl_chk #(.NBITS(NBITS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .sample_o     (sample_o),
    .midhold_o    (midhold_o),
    .ref_en_o     (ref_en_o),
    .sw_o         (sw_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .servo_pass_o (servo_pass_o)
);

// File: tb/sar_servo_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_servo_ctrl_tb_top;

    localparam int NB = 8;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [NB-1:0] tgt = '0;
    logic          cmp;
    logic          sample_o, midhold_o, ref_en_o, done_o, servo_pass_o;
    logic [NB-1:0] sw_o, result_o;

    int            vin = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [NB-1:0] last_res = '0;
    logic          last_pass = 1'b0;

    always #2.5 clk = ~clk;

    // Ideal comparator, input in quarter-LSB units.
    assign cmp = ref_en_o && (int'(sw_o) * 4 <= vin);

    sar_servo_ctrl #(.NBITS(NB), .SAMPLE_CYC(NS)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .servo_mode_i (mode),
        .target_i     (tgt),
        .cmp_i        (cmp),
        .sample_o     (sample_o),
        .midhold_o    (midhold_o),
        .ref_en_o     (ref_en_o),
        .sw_o         (sw_o),
        .done_o       (done_o),
        .result_o     (result_o),
        .servo_pass_o (servo_pass_o)
    );

    function automatic logic [11:0] ctl_vec(logic s, logic h, logic r, logic d, logic [7:0] w);
        return {s, h, r, d, w};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] act_ctl();
        return ctl_vec(sample_o, midhold_o, ref_en_o, done_o, sw_o);
    endfunction

    // R1: quiescent idle cycles, held outputs
    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            check("R1 idle controls", {4'd0, act_ctl()}, 16'd0);
            check("R5 held outputs", {7'd0, servo_pass_o, result_o}, {7'd0, last_pass, last_res});
        end
    endtask

    // Called at a negedge; start is driven immediately (back-to-back when chained, R8).
    task automatic conv(bit sv, int v, logic [7:0] t, bit disturb);
        int            len;
        logic [7:0]    er;
        logic          ep;
        logic [11:0]   ex;
        string         tag;
        len   = sv ? 5 : NS + 11;
        er    = 8'(v / 4);
        ep    = (v >= int'(t) * 4);
        start = 1'b1;
        mode  = sv;
        tgt   = t;
        vin   = v;
        for (int c = 1; c <= len; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (disturb && c == 3) begin
                start = 1'b1;     // R9: ignored
                mode  = ~sv;      // R10: ignored
                tgt   = ~t;       // R7: ignored
            end
            if (disturb && c == 4) start = 1'b0;
            if (sv) begin
                tag = "R6 servo step";
                case (c)
                    1:       ex = ctl_vec(1, 1, 0, 0, 8'h00);
                    2:       ex = ctl_vec(0, 0, 0, 0, 8'h00);
                    3:       ex = ctl_vec(0, 0, 0, 0, {t[7], 7'd0});
                    4:       ex = ctl_vec(0, 0, 1, 0, t);
                    default: ex = ctl_vec(0, 0, 0, 1, 8'h00);
                endcase
            end else if (c <= NS) begin
                tag = (c == 1) ? "R8/R2 sample" : "R2 sample";
                ex  = ctl_vec(1, 1, 0, 0, 8'h00);
            end else if (c == NS + 1) begin
                tag = "R3 decouple";
                ex  = ctl_vec(0, 0, 0, 0, 8'h00);
            end else if (c == NS + 2) begin
                tag = "R3 msb step";
                ex  = ctl_vec(0, 0, 0, 0, 8'h80);
            end else if (c < len) begin
                int i;
                int m;
                i   = NS + NB + 2 - c;
                m   = (int'(er) >> (i + 1)) << (i + 1);
                tag = "R4 trial";
                ex  = ctl_vec(0, 0, 1, 0, 8'(m | (1 << i)));
            end else begin
                tag = "R5 done";
                ex  = ctl_vec(0, 0, 0, 1, 8'h00);
            end
            if (disturb) tag = {tag, " R9/R10/R7"};
            check(tag, {4'd0, act_ctl()}, {4'd0, ex});
        end
        if (sv) begin
            check("R6 pass bit", {15'd0, servo_pass_o}, {15'd0, ep});
            check("R11 result untouched", {8'd0, result_o}, {8'd0, last_res});
            last_pass = ep;
        end else begin
            check("R4 result", {8'd0, result_o}, {8'd0, er});
            check("R11 pass untouched", {15'd0, servo_pass_o}, {15'd0, last_pass});
            last_res = er;
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check("R1 reset", {3'd0, act_ctl(), servo_pass_o}, 16'd0);
        check("R1 reset result", {8'd0, result_o}, 16'd0);
        rst = 1'b0;
        idle(2);
        // directed normal corners
        conv(0, 0, 8'h00, 0);
        conv(0, 1023, 8'h00, 0);
        conv(0, 512, 8'h00, 0);
        conv(0, 511, 8'h00, 0);
        idle(1);
        conv(0, 4, 8'h00, 0);
        conv(0, 3, 8'h00, 0);
        // directed servo edges
        conv(1, 400, 8'd100, 0);
        conv(1, 399, 8'd100, 0);
        conv(1, 401, 8'd100, 0);
        conv(1, 0, 8'd0, 0);
        conv(1, 1023, 8'd255, 0);
        idle(2);
        // mid-conversion disturbance in both modes
        conv(0, 700, 8'h3C, 1);
        conv(1, 300, 8'd75, 1);
        conv(1, 299, 8'd75, 1);
        idle(1);
        // constrained random
        for (int n = 0; n < 120; n++) begin
            bit   sv;
            int   v;
            int   t;
            sv = ($urandom % 3) == 0;
            v  = int'($urandom % 1024);
            t  = int'($urandom % 256);
            if ($urandom % 2) begin
                t = v / 4 + int'($urandom % 3) - 1;
                if (t < 0) t = 0;
                if (t > 255) t = 255;
            end
            conv(sv, v, 8'(t), ($urandom % 5) == 0);
            idle(int'($urandom % 3));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule